// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block moves data between system memory and a peripheral data FIFO. It does not take a single address and length. It walks a chain of 16-byte descriptors that software builds in memory. Each descriptor gives a byte count, a data buffer address, a pointer to the next descriptor and a flag that marks the last descriptor in the chain.

Software programs the block through a small 32-bit register window. The steps are: enable the engine, point it at the first descriptor, choose a direction and set the run bit. The engine then fetches each descriptor and moves the data a word at a time over a request/grant memory port. It follows the chain until it meets the last descriptor or an error. When it stops, it clears the run bit, writes an outcome code into the channel control register and raises its interrupt status. Writes to channel control are ignored while a chain is in progress.

Top module: `chain_dma`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and no memory request, transmit word or receive acceptance is asserted.
- R2: The register offsets are: 0x00 global control, 0x04 interrupt enable, 0x08 interrupt status, 0x0C descriptor pointer, 0x20 channel control. Global control bit 0 (enable), interrupt enable bit 0 and the descriptor pointer read back as they were written.
- R3: A descriptor is fetched as three word reads, in the order pointer, pointer+4, pointer+8. Word 0 holds the byte count in bits 15:0 and the last-descriptor flag in bit 31. Word 1 holds the buffer address. Word 2 holds the next-descriptor address.
- R4: With channel control bit 22 clear, the buffer words are read in ascending address order and presented on `tx_data` in that order. A byte count that is not a multiple of four is rounded up to whole words.
- R5: With channel control bit 22 set, received words are written to the buffer in ascending address order.
- R6: Outcome codes live in channel control bits 3:0. When a descriptor without the last flag completes, the engine fetches the descriptor at its next address. When a descriptor with the last flag completes, the engine stops, clears run (bit 7) and reports code 0xF.
- R7: An error response to any descriptor word read stops the engine with code 3. No further memory access follows.
- R8: An error response to a buffer read or write stops the engine with code 4.
- R9: The engine stops with code 5 if a received word flagged `rx_last` leaves part of the byte count unfilled. That word is still written to memory.
- R10: Interrupt status bit 0 is set whenever the engine stops and is cleared by writing 1 to it. `irq` is high exactly when both status bit 0 and interrupt enable bit 0 are set.
- R11: A run request written while global control bit 0 is clear is ignored: run reads back 0 and no memory request follows.
- R12: Writing global control with bit 8 set aborts any transfer and clears global control, channel control and interrupt status.
- R13: `mem_req` and `mem_addr` stay stable until granted. `tx_valid` and `tx_data` stay stable until accepted. At most one of `mem_req`, `tx_valid` and `rx_ready` is high at a time.
- R14: A descriptor with byte count zero moves no data, and the chain continues through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| mem_err | input | 1 | Error response, valid with mem_gnt |
| tx_valid | output | 1 | Word offered to peripheral |
| tx_data | output | 32 | Word to peripheral |
| tx_ready | input | 1 | Peripheral accepts word |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_data | input | 32 | Word from peripheral |
| rx_last | input | 1 | Peripheral has no more data after this word |
| rx_ready | output | 1 | Engine accepts received word |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the points where chain walking goes wrong. It runs a two-descriptor chain with an odd byte count, where an engine that ignored the next pointer or truncated the count would deliver too few words. It also runs a zero-count descriptor placed mid-chain, which a careless engine would treat as one word or as the end. Error responses are placed on a descriptor word and on a buffer word, and the bench checks both the outcome code and that memory traffic stops at once, since an engine that kept going would corrupt memory or report the wrong code. A receive stream ending early checks the code-5 path, and the word after the last written one is inspected to confirm nothing stray was written. A soft reset issued while the peripheral stalls checks that the engine really releases its ports.

// File: rtl/chain_dma_pkg.sv
// Shared constants and types for the linked-descriptor DMA channel.
package chain_dma_pkg;

    // Register byte offsets inside the register window
    localparam logic [7:0] OFF_GCTL = 8'h00;
    localparam logic [7:0] OFF_IEN  = 8'h04;
    localparam logic [7:0] OFF_ISTS = 8'h08;
    localparam logic [7:0] OFF_DPTR = 8'h0C;
    localparam logic [7:0] OFF_CCTL = 8'h20;

    // Bit positions used by software and hardware alike
    localparam int GCTL_EN   = 0;
    localparam int GCTL_SRST = 8;
    localparam int CCTL_RUN  = 7;
    localparam int CCTL_DIR  = 22;

    // Outcome codes reported in channel control bits 3:0
    typedef enum logic [3:0] {
        OC_NONE     = 4'h0,
        OC_UNDER    = 4'h1,
        OC_OVER     = 4'h2,
        OC_DESC_ERR = 4'h3,
        OC_DATA_ERR = 4'h4,
        OC_EARLY    = 4'h5,
        OC_OK       = 4'hF
    } outcome_e;

    // Descriptor walker states
    typedef enum logic [3:0] {
        W_IDLE, W_FD0, W_FD1, W_FD2, W_MRD, W_TXP, W_RXW, W_MWR, W_NEXT
    } walk_state_e;

endpackage

// File: rtl/chain_dma_regs.sv
// Register window of the DMA channel.
// Holds global control, interrupt enable/status, descriptor pointer and
// channel control. Turns a run write into a start pulse for the walker
// and a soft-reset write into an abort pulse. Assumes reads are
// combinational on reg_addr and writes take effect on the clock edge.
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              fin_i,
    input  logic [3:0]        fin_code_i,
    output logic              start_o,
    output logic              abort_o,
    output logic [ADDR_W-1:0] desc_ptr_o,
    output logic              dir_o,
    output logic              irq_o
);

    logic              gctl_en;
    logic              ien_q;
    logic              ists_q;
    logic [ADDR_W-1:0] dptr_q;
    logic              run_q;
    logic              dir_q;
    logic [3:0]        code_q;

    logic wr_gctl, wr_ien, wr_ists, wr_dptr, wr_cctl;

    // Decode write strobes per register
    always_comb begin
        wr_gctl = reg_wen && (reg_addr == OFF_GCTL);
        wr_ien  = reg_wen && (reg_addr == OFF_IEN);
        wr_ists = reg_wen && (reg_addr == OFF_ISTS);
        wr_dptr = reg_wen && (reg_addr == OFF_DPTR);
        wr_cctl = reg_wen && (reg_addr == OFF_CCTL);
    end

    assign abort_o = wr_gctl && reg_wdata[GCTL_SRST];
    assign start_o = wr_cctl && reg_wdata[CCTL_RUN] && gctl_en && !busy_i;

    // Global control: enable bit, cleared by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)       gctl_en <= 1'b0;
        else if (wr_gctl) gctl_en <= reg_wdata[GCTL_EN] && !reg_wdata[GCTL_SRST];
    end

    // Interrupt enable and descriptor pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            dptr_q <= '0;
        end else begin
            if (wr_ien)  ien_q  <= reg_wdata[0];
            if (wr_dptr) dptr_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // Interrupt status: set on finish, write-1-to-clear, wiped by abort
    always_ff @(posedge clk) begin
        if (!rst_n)                       ists_q <= 1'b0;
        else if (abort_o)                 ists_q <= 1'b0;
        else if (fin_i)                   ists_q <= 1'b1;
        else if (wr_ists && reg_wdata[0]) ists_q <= 1'b0;
    end

    // Channel control: run, direction and outcome code
    always_ff @(posedge clk) begin
        if (!rst_n || abort_o) begin
            run_q  <= 1'b0;
            dir_q  <= 1'b0;
            code_q <= OC_NONE;
        end else if (fin_i) begin
            run_q  <= 1'b0;
            code_q <= fin_code_i;
        end else if (wr_cctl && !busy_i) begin
            run_q  <= start_o;
            dir_q  <= reg_wdata[CCTL_DIR];
            code_q <= OC_NONE;
        end
    end

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_GCTL: reg_rdata[GCTL_EN] = gctl_en;
            OFF_IEN:  reg_rdata[0] = ien_q;
            OFF_ISTS: reg_rdata[0] = ists_q;
            OFF_DPTR: reg_rdata[ADDR_W-1:0] = dptr_q;
            OFF_CCTL: begin
                reg_rdata[3:0]      = code_q;
                reg_rdata[CCTL_RUN] = run_q;
                reg_rdata[CCTL_DIR] = dir_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign desc_ptr_o = dptr_q;
    assign dir_o      = reg_wdata[CCTL_DIR];
    assign irq_o      = ists_q && ien_q;

    // R6/R10: a finish clears run, latches the code and raises status
    p_finish_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i && !abort_o |=> !run_q && ists_q && (code_q == $past(fin_code_i)));

    // R12: soft reset leaves channel, enable and status clear
    p_abort_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !run_q && !gctl_en && !ists_q && (code_q == OC_NONE));

endmodule

// File: rtl/chain_dma_walker.sv
// Descriptor walker and data mover.
// Fetches three header words per descriptor, then moves whole words between
// the buffer and the peripheral port in the selected direction, and follows
// the chain until the last flag or an error. Assumes mem_rdata and mem_err
// are valid in the cycle mem_gnt is high. Emits a one-cycle finish pulse
// with the outcome code.
module chain_dma_walker
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              dir_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic [3:0]        fin_code_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready
);

    localparam int                WB    = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WB);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * WB);
    localparam logic [CNT_W-1:0]  WBC   = CNT_W'(WB);

    walk_state_e       state;
    logic [ADDR_W-1:0] ptr, br, cur;
    logic [CNT_W-1:0]  rem, rem_next;
    logic              endf, dir, last;
    logic [DATA_W-1:0] hold;
    logic              fin_q;
    logic [3:0]        code_q;

    // Bytes left after one more word moves, saturating at zero
    always_comb rem_next = (rem > WBC) ? (rem - WBC) : '0;

    // Walk the chain: fetch, move, branch or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= W_IDLE;
            ptr    <= '0;
            br     <= '0;
            cur    <= '0;
            rem    <= '0;
            endf   <= 1'b0;
            dir    <= 1'b0;
            last   <= 1'b0;
            hold   <= '0;
            fin_q  <= 1'b0;
            code_q <= OC_NONE;
        end else begin
            fin_q <= 1'b0;
            if (abort_i) begin
                state <= W_IDLE;
            end else begin
                case (state)
                    W_IDLE: if (start_i) begin
                        ptr   <= ptr_i;
                        dir   <= dir_i;
                        state <= W_FD0;
                    end
                    W_FD0: if (mem_gnt) begin
                        if (mem_err) begin
                            fin_q <= 1'b1; code_q <= OC_DESC_ERR; state <= W_IDLE;
                        end else begin
                            rem   <= mem_rdata[CNT_W-1:0];
                            endf  <= mem_rdata[DATA_W-1];
                            state <= W_FD1;
                        end
                    end
                    W_FD1: if (mem_gnt) begin
                        if (mem_err) begin
                            fin_q <= 1'b1; code_q <= OC_DESC_ERR; state <= W_IDLE;
                        end else begin
                            cur   <= {mem_rdata[ADDR_W-1:2], 2'b00};
                            state <= W_FD2;
                        end
                    end
                    W_FD2: if (mem_gnt) begin
                        if (mem_err) begin
                            fin_q <= 1'b1; code_q <= OC_DESC_ERR; state <= W_IDLE;
                        end else begin
                            br <= {mem_rdata[ADDR_W-1:2], 2'b00};
                            if (rem == '0) state <= W_NEXT;
                            else if (dir)  state <= W_RXW;
                            else           state <= W_MRD;
                        end
                    end
                    W_MRD: if (mem_gnt) begin
                        if (mem_err) begin
                            fin_q <= 1'b1; code_q <= OC_DATA_ERR; state <= W_IDLE;
                        end else begin
                            hold  <= mem_rdata;
                            state <= W_TXP;
                        end
                    end
                    W_TXP: if (tx_ready) begin
                        cur   <= cur + STEP;
                        rem   <= rem_next;
                        state <= (rem_next == '0) ? W_NEXT : W_MRD;
                    end
                    W_RXW: if (rx_valid) begin
                        hold  <= rx_data;
                        last  <= rx_last;
                        state <= W_MWR;
                    end
                    W_MWR: if (mem_gnt) begin
                        if (mem_err) begin
                            fin_q <= 1'b1; code_q <= OC_DATA_ERR; state <= W_IDLE;
                        end else begin
                            cur <= cur + STEP;
                            rem <= rem_next;
                            if (rem_next == '0) begin
                                state <= W_NEXT;
                            end else if (last) begin
                                fin_q <= 1'b1; code_q <= OC_EARLY; state <= W_IDLE;
                            end else begin
                                state <= W_RXW;
                            end
                        end
                    end
                    W_NEXT: begin
                        if (endf) begin
                            fin_q <= 1'b1; code_q <= OC_OK; state <= W_IDLE;
                        end else begin
                            ptr   <= br;
                            state <= W_FD0;
                        end
                    end
                    default: state <= W_IDLE;
                endcase
            end
        end
    end

    // Memory port drive derived from the current state
    always_comb begin
        mem_req  = (state == W_FD0) || (state == W_FD1) || (state == W_FD2) ||
                   (state == W_MRD) || (state == W_MWR);
        mem_we   = (state == W_MWR);
        case (state)
            W_FD1:        mem_addr = ptr + STEP;
            W_FD2:        mem_addr = ptr + STEP2;
            W_MRD, W_MWR: mem_addr = cur;
            default:      mem_addr = ptr;
        endcase
        mem_wdata = hold;
    end

    assign tx_valid   = (state == W_TXP);
    assign tx_data    = hold;
    assign rx_ready   = (state == W_RXW);
    assign busy_o     = (state != W_IDLE);
    assign fin_o      = fin_q;
    assign fin_code_o = code_q;

    // R13: an ungranted request holds its address and kind
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt && !abort_i |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R13: an unaccepted transmit word stays put
    p_tx_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !abort_i |=> tx_valid && $stable(tx_data));

    // R13: only one port is active in any cycle
    p_one_port_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, tx_valid, rx_ready}));

    // R7: a finish always carries one of the codes the walker can produce
    p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (code_q == OC_DESC_ERR) || (code_q == OC_DATA_ERR) ||
                  (code_q == OC_EARLY) || (code_q == OC_OK));

endmodule

// File: rtl/chain_dma.sv
// Top of the linked-descriptor DMA channel.
// Joins the register window to the descriptor walker. Assumes a single
// clock domain and a memory port that answers in its grant cycle.
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              irq
);

    logic              start, abort, dir, walk_busy, fin, busy_any;
    logic [3:0]        fin_code;
    logic [ADDR_W-1:0] ptr;

    // The channel counts as busy until its finish has been recorded
    assign busy_any = walk_busy || fin;

    chain_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy_i(busy_any), .fin_i(fin), .fin_code_i(fin_code),
        .start_o(start), .abort_o(abort), .desc_ptr_o(ptr), .dir_o(dir),
        .irq_o(irq)
    );

    chain_dma_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .abort_i(abort), .ptr_i(ptr), .dir_i(dir),
        .busy_o(walk_busy), .fin_o(fin), .fin_code_o(fin_code),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready)
    );

endmodule

// File: tb/chain_dma_test.sv
`timescale 1ns/1ps
module chain_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        irq;

    always #2 clk = ~clk;

    chain_dma uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .irq(irq)
    );

    int total = 0;
    int bad = 0;

    logic [31:0] mem [0:511];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    int          gnt_mode = 0;
    int          rdy_mode = 0;
    logic        tx_stall = 1'b0;
    logic        gtick = 1'b0;
    logic        ttick = 1'b0;
    logic [31:0] exp_tx [$];
    logic [32:0] rx_q [$];
    logic [31:0] rd_log [$];
    int          wr_cnt = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: grant decided at the falling edge, transfer at the next rise
    always @(negedge clk) begin
        gtick = ~gtick;
        mem_gnt = mem_req && (gnt_mode == 0 || gtick);
        mem_err = 1'b0;
        if (mem_gnt) begin
            mem_err = (mem_addr == err_addr);
            mem_rdata = mem[mem_addr[10:2]];
            if (mem_we) begin
                if (!mem_err) mem[mem_addr[10:2]] = mem_wdata;
                wr_cnt++;
            end else begin
                rd_log.push_back(mem_addr);
            end
        end
    end

    // Transmit monitor: pops the scoreboard on every accepted word (R4)
    always @(negedge clk) begin
        ttick = ~ttick;
        tx_ready = !tx_stall && (rdy_mode == 0 || ttick);
        if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) check("R4 unexpected tx word", tx_data, 32'hxxxx_xxxx);
            else check("R4 tx word order", tx_data, exp_tx.pop_front());
        end
    end

    // Receive source: presents queued words, last flag in bit 32
    always @(negedge clk) begin
        rx_valid = rx_q.size() > 0;
        if (rx_valid) begin
            rx_data = rx_q[0][31:0];
            rx_last = rx_q[0][32];
            if (rx_ready) void'(rx_q.pop_front());
        end else begin
            rx_last = 1'b0;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [15:0] cnt, input logic last,
                            input logic [31:0] buf_a, input logic [31:0] nxt);
        mem[at[10:2]]       = {last, 1'b1, 14'd0, cnt};
        mem[at[10:2] + 9'd1] = buf_a;
        mem[at[10:2] + 9'd2] = nxt;
    endtask

    task automatic wait_idle(output logic [31:0] cc);
        cc = 32'h80;
        for (int i = 0; i < 3000 && cc[7]; i++) rd(8'h20, cc);
    endtask

    logic [31:0] v;

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'hC000_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, v); check("R1 gctl", v, 0);
        rd(8'h04, v); check("R1 ien", v, 0);
        rd(8'h08, v); check("R1 ists", v, 0);
        rd(8'h0C, v); check("R1 dptr", v, 0);
        rd(8'h20, v); check("R1 cctl", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 ports", {29'd0, mem_req, tx_valid, rx_ready}, 0);

        // R11: run while disabled is ignored
        wr(8'h0C, 32'h100);
        wr(8'h20, 32'h80);
        rd(8'h20, v); check("R11 run stays 0", v, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R11 no mem_req", {31'd0, mem_req}, 0);
        end

        // R2: register readback
        wr(8'h04, 1); rd(8'h04, v); check("R2 ien readback", v, 1);
        wr(8'h0C, 32'h100); rd(8'h0C, v); check("R2 dptr readback", v, 32'h100);
        wr(8'h00, 1); rd(8'h00, v); check("R2 gctl enable", v, 1);

        // R3/R4/R6: two-descriptor transmit chain, odd count on the last
        put_desc(32'h100, 16'd8, 1'b0, 32'h200, 32'h140);
        put_desc(32'h140, 16'd6, 1'b1, 32'h300, 32'h0);
        exp_tx.push_back(mem[32'h200 >> 2]); exp_tx.push_back(mem[32'h204 >> 2]);
        exp_tx.push_back(mem[32'h300 >> 2]); exp_tx.push_back(mem[32'h304 >> 2]);
        rd_log.delete();
        rdy_mode = 1;
        wr(8'h20, 32'h80);
        wait_idle(v);
        check("R6 code ok and run clear", v, 32'h0000_000F);
        check("R4 all words delivered", exp_tx.size(), 0);
        check("R3 fetch count", rd_log.size(), 10);
        check("R3 word0 addr", rd_log[0], 32'h100);
        check("R3 word1 addr", rd_log[1], 32'h104);
        check("R3 word2 addr", rd_log[2], 32'h108);
        check("R6 branch fetch", rd_log[5], 32'h140);
        check("R4 rounded read", rd_log[9], 32'h304);
        rd(8'h08, v); check("R10 status set", v, 1);
        check("R10 irq high", {31'd0, irq}, 1);
        wr(8'h08, 1); rd(8'h08, v); check("R10 status cleared", v, 0);
        check("R10 irq low", {31'd0, irq}, 0);

        // R5/R13: receive with grant stalls, interrupt disabled
        wr(8'h04, 0);
        put_desc(32'h180, 16'd12, 1'b1, 32'h400, 32'h0);
        rx_q.push_back({1'b0, 32'h1111_0001});
        rx_q.push_back({1'b0, 32'h1111_0002});
        rx_q.push_back({1'b0, 32'h1111_0003});
        gnt_mode = 1;
        wr(8'h0C, 32'h180);
        wr(8'h20, 32'h0040_0080);
        wait_idle(v);
        check("R5 code ok, dir kept", v, 32'h0040_000F);
        check("R5 word0", mem[32'h400 >> 2], 32'h1111_0001);
        check("R5 word1", mem[32'h404 >> 2], 32'h1111_0002);
        check("R13 word2 under stalls", mem[32'h408 >> 2], 32'h1111_0003);
        rd(8'h08, v); check("R10 status without enable", v, 1);
        check("R10 irq masked", {31'd0, irq}, 0);

        // R9: early end of received data
        put_desc(32'h1A0, 16'd16, 1'b1, 32'h410, 32'h0);
        rx_q.push_back({1'b0, 32'h2222_0001});
        rx_q.push_back({1'b1, 32'h2222_0002});
        wr(8'h0C, 32'h1A0);
        wr(8'h20, 32'h0040_0080);
        wait_idle(v);
        check("R9 early end code", v[3:0], 4'h5);
        check("R9 last word written", mem[32'h414 >> 2], 32'h2222_0002);
        check("R9 nothing beyond", mem[32'h418 >> 2], 32'hC000_0000 | (32'h418 >> 2));
        gnt_mode = 0;

        // R7: error on second descriptor's buffer word
        err_addr = 32'h144;
        exp_tx.push_back(mem[32'h200 >> 2]); exp_tx.push_back(mem[32'h204 >> 2]);
        rd_log.delete();
        wr(8'h0C, 32'h100);
        wr(8'h20, 32'h80);
        wait_idle(v);
        repeat (5) @(negedge clk);
        check("R7 fetch error code", v, 32'h3);
        check("R7 stops at faulting read", rd_log.size(), 7);
        check("R7 tx words", exp_tx.size(), 0);

        // R8: error on a buffer read
        err_addr = 32'h204;
        exp_tx.push_back(mem[32'h200 >> 2]);
        wr(8'h20, 32'h80);
        wait_idle(v);
        check("R8 data error code", v, 32'h4);
        check("R8 one word delivered", exp_tx.size(), 0);
        err_addr = 32'hFFFF_FFF0;

        // R12: soft reset while the peripheral stalls
        tx_stall = 1'b1;
        exp_tx.push_back(mem[32'h200 >> 2]);
        wr(8'h20, 32'h80);
        repeat (20) @(negedge clk);
        check("R12 stalled on tx", {31'd0, tx_valid}, 1);
        wr(8'h00, 32'h100);
        rd(8'h20, v); check("R12 cctl cleared", v, 0);
        rd(8'h00, v); check("R12 gctl cleared", v, 0);
        rd(8'h08, v); check("R12 status cleared", v, 0);
        check("R12 ports released", {29'd0, mem_req, tx_valid, rx_ready}, 0);
        exp_tx.delete();
        tx_stall = 1'b0;
        rdy_mode = 0;

        // R14: zero-count descriptor in mid-chain
        wr(8'h00, 1);
        put_desc(32'h1C0, 16'd0, 1'b0, 32'h380, 32'h1E0);
        put_desc(32'h1E0, 16'd4, 1'b1, 32'h300, 32'h0);
        exp_tx.push_back(mem[32'h300 >> 2]);
        wr_cnt = 0;
        wr(8'h0C, 32'h1C0);
        wr(8'h20, 32'h80);
        wait_idle(v);
        check("R14 chain completes", v, 32'hF);
        check("R14 single word", exp_tx.size(), 0);
        check("R14 no writes", wr_cnt, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule